// File: doc/BRIEF.md
# Haar Feature Rectangle Evaluator

This block scores one Haar-like feature at one detection window position. A feature is handed over in one transfer. The transfer carries the window origin, a rectangle count, up to four rectangle descriptors, a threshold and two leaf values. Each descriptor holds an x/y offset from the window origin, a width and height, and a signed fixed-point weight.

The block latches the feature and visits the rectangles one after another. For each rectangle it reads four corner entries from an external integral-image port, with one request outstanding at a time. From those entries it forms the rectangle sum. It multiplies the sum by the weight and adds the product to a wide accumulator that never saturates. After the last rectangle it compares the total with the threshold and emits one of the two leaf values with a one-cycle valid pulse.

Building the integral image and sequencing the cascade stages are handled elsewhere. A cascade controller drives this block one feature at a time.

Top module: `haar_feat_eval`

## Requirements
- R1: After reset, `feat_ready` is 1 and both `res_valid` and `ii_req_valid` are 0.
- R2: A feature is taken only in a cycle where `feat_ready` and `feat_valid` are both 1. All descriptor, threshold and leaf inputs are captured in that cycle. `feat_valid` and input changes while busy have no effect on the result.
- R3: `feat_nrect` gives the rectangle count. Values 2 to 4 are used as given, 0 and 1 act as 2, and 5 to 7 act as 4. Each rectangle costs exactly four integral-image requests, so a feature issues 4 × count requests.
- R4: Rectangle i (fields at bit slice i×8 +: 8, weight likewise) is visited in index order starting at 0. With x0 = win_x+dx, y0 = win_y+dy, x1 = x0+w and y1 = y0+h, its corner requests are (x0,y0), (x1,y0), (x0,y1), (x1,y1), in that order. A request is a one-cycle pulse, and the next one is issued only after the response.
- R5: The rectangle sum is E(x0,y0) − E(x1,y0) − E(x0,y1) + E(x1,y1), where the E are 25-bit unsigned responses.
- R6: Weights are 8-bit two's complement with 5 fraction bits (−4.0 to +3.96875). Each sum × weight product is accumulated at full precision, without saturation, including four products at full 25-bit scale.
- R7: The threshold uses the same 8-bit format. If the accumulated value is strictly below the threshold, `res_value` is `leaf_lo`; otherwise, equality included, it is `leaf_hi`.
- R8: `res_valid` is a single-cycle pulse, and `feat_ready` is 1 in that same cycle.
- R9: Any response latency of one cycle or more gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| feat_valid | input | 1 | Feature offered |
| feat_ready | output | 1 | Block idle, feature can be taken |
| feat_nrect | input | 3 | Rectangle count |
| win_x | input | 10 | Window origin x |
| win_y | input | 10 | Window origin y |
| rect_dx | input | 32 | Per-rectangle x offsets, 8 bits each |
| rect_dy | input | 32 | Per-rectangle y offsets |
| rect_w | input | 32 | Per-rectangle widths |
| rect_h | input | 32 | Per-rectangle heights |
| rect_wt | input | 32 | Per-rectangle weights, signed 2.5 fixed point |
| feat_thr | input | 8 | Threshold, signed 2.5 fixed point |
| leaf_lo | input | 8 | Result when below threshold |
| leaf_hi | input | 8 | Result otherwise |
| ii_req_valid | output | 1 | Integral-image read request |
| ii_req_x | output | 10 | Requested x coordinate |
| ii_req_y | output | 10 | Requested y coordinate |
| ii_rsp_valid | input | 1 | Read response valid |
| ii_rsp_data | input | 25 | Integral-image entry |
| res_valid | output | 1 | Result pulse |
| res_value | output | 8 | Selected leaf value |

## Verification
Several protocol properties are checked on every cycle by assertions:
- requests are single-cycle pulses, and none is issued while idle;
- results are single pulses that arrive with `feat_ready` high;
- each result carries one of the two captured leaf values;
- each feature issues exactly four requests per effective rectangle.

Other behaviour needs the bench's scenarios and its reference model over a random integral image. This covers the numerical path: corner signs, corner order, the weighted sum with full-scale entries that would overflow 32 bits, and the tie at the threshold. The count clamping, immunity to input changes while busy and tolerance of slow responses are also shown this way.

// File: rtl/haar_pkg.sv
package haar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_MAC,
    ST_CMP
  } fsm_e;
endpackage

// File: rtl/haar_corner_addr.sv
// Corner coordinate and sign for the current rectangle.
// Corner order: 0 (x0,y0)+, 1 (x1,y0)-, 2 (x0,y1)-, 3 (x1,y1)+.
module haar_corner_addr #(
  parameter int AW  = 10,
  parameter int OFW = 8
) (
  input  logic [AW-1:0]  org_x,
  input  logic [AW-1:0]  org_y,
  input  logic [OFW-1:0] off_x,
  input  logic [OFW-1:0] off_y,
  input  logic [OFW-1:0] size_w,
  input  logic [OFW-1:0] size_h,
  input  logic [1:0]     corner,
  output logic [AW-1:0]  addr_x,
  output logic [AW-1:0]  addr_y,
  output logic           negate
);
  always_comb begin
    addr_x = org_x + AW'(off_x) + (corner[0] ? AW'(size_w) : '0);
    addr_y = org_y + AW'(off_y) + (corner[1] ? AW'(size_h) : '0);
    negate = corner[0] ^ corner[1];
  end
endmodule

// File: rtl/haar_sum_acc.sv
// Signed running sum of the four corner entries of one rectangle.
module haar_sum_acc #(
  parameter int IIW  = 25,
  parameter int SUMW = IIW + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic                   negate,
  input  logic [IIW-1:0]         data,
  output logic signed [SUMW-1:0] sum
);
  logic signed [SUMW-1:0] sum_q, sum_d, ext;

  assign ext = $signed({{(SUMW-IIW){1'b0}}, data});

  always_comb begin
    sum_d = sum_q;
    if (clr)     sum_d = '0;
    else if (en) sum_d = negate ? (sum_q - ext) : (sum_q + ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/haar_feat_mac.sv
// Weighted accumulation, threshold compare and leaf selection.
module haar_feat_mac #(
  parameter int SUMW = 27,
  parameter int FXW  = 8,
  parameter int NMAX = 4,
  localparam int PRODW = SUMW + FXW,
  localparam int ACCW  = PRODW + $clog2(NMAX) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   mac_en,
  input  logic                   cmp_en,
  input  logic signed [SUMW-1:0] sum_in,
  input  logic signed [FXW-1:0]  weight,
  input  logic signed [FXW-1:0]  thr,
  input  logic [FXW-1:0]         leaf_l,
  input  logic [FXW-1:0]         leaf_r,
  output logic                   res_valid,
  output logic [FXW-1:0]         res_value
);
  logic signed [PRODW-1:0] prod;
  logic signed [ACCW-1:0]  acc_q, acc_d, thr_ext;
  logic                    vld_q, vld_d;
  logic [FXW-1:0]          val_q, val_d;

  // Sum has no fraction bits, weight and threshold share the same
  // fraction width, so the product and threshold are on one scale.
  assign prod    = sum_in * weight;
  assign thr_ext = ACCW'(thr);

  always_comb begin
    acc_d = acc_q;
    if (clr)         acc_d = '0;
    else if (mac_en) acc_d = acc_q + ACCW'(prod);
    vld_d = cmp_en;
    val_d = val_q;
    if (cmp_en) val_d = (acc_q < thr_ext) ? leaf_l : leaf_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
      val_q <= '0;
    end else begin
      acc_q <= acc_d;
      vld_q <= vld_d;
      val_q <= val_d;
    end
  end

  assign res_valid = vld_q;
  assign res_value = val_q;

  // R7: the result is always one of the two captured leaves
  a_r7_leaf_pick: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_value == leaf_l || res_value == leaf_r));
endmodule

// File: rtl/haar_feat_eval.sv
module haar_feat_eval
  import haar_pkg::*;
#(
  parameter int AW   = 10,
  parameter int OFW  = 8,
  parameter int FXW  = 8,
  parameter int IIW  = 25,
  parameter int NMAX = 4,
  localparam int NW   = $clog2(NMAX) + 1,
  localparam int RIW  = $clog2(NMAX),
  localparam int SUMW = IIW + 2,
  localparam int RCW  = $clog2(4 * NMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 feat_valid,
  output logic                 feat_ready,
  input  logic [NW-1:0]        feat_nrect,
  input  logic [AW-1:0]        win_x,
  input  logic [AW-1:0]        win_y,
  input  logic [NMAX*OFW-1:0]  rect_dx,
  input  logic [NMAX*OFW-1:0]  rect_dy,
  input  logic [NMAX*OFW-1:0]  rect_w,
  input  logic [NMAX*OFW-1:0]  rect_h,
  input  logic [NMAX*FXW-1:0]  rect_wt,
  input  logic [FXW-1:0]       feat_thr,
  input  logic [FXW-1:0]       leaf_lo,
  input  logic [FXW-1:0]       leaf_hi,
  output logic                 ii_req_valid,
  output logic [AW-1:0]        ii_req_x,
  output logic [AW-1:0]        ii_req_y,
  input  logic                 ii_rsp_valid,
  input  logic [IIW-1:0]       ii_rsp_data,
  output logic                 res_valid,
  output logic [FXW-1:0]       res_value
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  fsm_e             state_q, state_d;
  logic [1:0]       corner_q, corner_d;
  logic [RIW-1:0]   ridx_q, ridx_d, last_q, last_d;
  logic [AW-1:0]    ox_q, oy_q;
  logic [NMAX*OFW-1:0] dx_q, dy_q, w_q, h_q;
  logic [NMAX*FXW-1:0] wt_q;
  logic [FXW-1:0]   thr_q, lo_q, hi_q;
  logic             accept, negate;
  logic signed [SUMW-1:0] rect_sum;

  assign accept = (state_q == ST_IDLE) && feat_valid;

  // Effective last rectangle index after clamping the count
  always_comb begin
    if (feat_nrect < NW'(2))         last_d = RIW'(1);
    else if (feat_nrect > NW'(NMAX)) last_d = RIW'(NMAX - 1);
    else                             last_d = RIW'(feat_nrect - NW'(1));
  end

  always_comb begin
    state_d  = state_q;
    corner_d = corner_q;
    ridx_d   = ridx_q;
    unique case (state_q)
      ST_IDLE: if (feat_valid) begin
        state_d  = ST_ISSUE;
        corner_d = '0;
        ridx_d   = '0;
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: if (ii_rsp_valid) begin
        if (corner_q == 2'd3) state_d = ST_MAC;
        else begin
          corner_d = corner_q + 2'd1;
          state_d  = ST_ISSUE;
        end
      end
      ST_MAC: if (ridx_q == last_q) state_d = ST_CMP;
      else begin
        ridx_d   = ridx_q + RIW'(1);
        corner_d = '0;
        state_d  = ST_ISSUE;
      end
      ST_CMP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      corner_q <= '0;
      ridx_q   <= '0;
    end else begin
      state_q  <= state_d;
      corner_q <= corner_d;
      ridx_q   <= ridx_d;
    end
  end

  // Feature capture, enabled by acceptance only
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      last_q <= '0; ox_q <= '0; oy_q <= '0;
      dx_q <= '0; dy_q <= '0; w_q <= '0; h_q <= '0; wt_q <= '0;
      thr_q <= '0; lo_q <= '0; hi_q <= '0;
    end else if (accept) begin
      last_q <= last_d; ox_q <= win_x; oy_q <= win_y;
      dx_q <= rect_dx; dy_q <= rect_dy; w_q <= rect_w; h_q <= rect_h;
      wt_q <= rect_wt; thr_q <= feat_thr; lo_q <= leaf_lo; hi_q <= leaf_hi;
    end
  end

  haar_corner_addr #(.AW(AW), .OFW(OFW)) addr_i (
    .org_x (ox_q),
    .org_y (oy_q),
    .off_x (dx_q[ridx_q*OFW +: OFW]),
    .off_y (dy_q[ridx_q*OFW +: OFW]),
    .size_w(w_q[ridx_q*OFW +: OFW]),
    .size_h(h_q[ridx_q*OFW +: OFW]),
    .corner(corner_q),
    .addr_x(ii_req_x),
    .addr_y(ii_req_y),
    .negate(negate)
  );

  haar_sum_acc #(.IIW(IIW), .SUMW(SUMW)) sum_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (accept || state_q == ST_MAC),
    .en    (state_q == ST_WAIT && ii_rsp_valid),
    .negate(negate),
    .data  (ii_rsp_data),
    .sum   (rect_sum)
  );

  haar_feat_mac #(.SUMW(SUMW), .FXW(FXW), .NMAX(NMAX)) mac_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (accept),
    .mac_en   (state_q == ST_MAC),
    .cmp_en   (state_q == ST_CMP),
    .sum_in   (rect_sum),
    .weight   ($signed(wt_q[ridx_q*FXW +: FXW])),
    .thr      ($signed(thr_q)),
    .leaf_l   (lo_q),
    .leaf_r   (hi_q),
    .res_valid(res_valid),
    .res_value(res_value)
  );

  assign feat_ready   = (state_q == ST_IDLE);
  assign ii_req_valid = (state_q == ST_ISSUE);

  // Request counter used only by the count check below
  logic [RCW-1:0] rcnt_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)       rcnt_q <= '0;
    else if (accept)       rcnt_q <= '0;
    else if (ii_req_valid) rcnt_q <= rcnt_q + RCW'(1);
  end

  a_r3_req_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> rcnt_q == RCW'(4) * (RCW'(last_q) + RCW'(1)));
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ii_req_valid |=> !ii_req_valid);
  a_r2_no_req_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    feat_ready |-> !ii_req_valid);
  a_r8_res_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |=> !res_valid);
  a_r8_ready_with_res: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> feat_ready);
endmodule

// File: tb/haar_feat_eval_tb.sv
`timescale 1ns/1ps
module haar_feat_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        feat_valid, feat_ready;
  logic [2:0]  feat_nrect;
  logic [9:0]  win_x, win_y;
  logic [31:0] rect_dx, rect_dy, rect_w, rect_h, rect_wt;
  logic [7:0]  feat_thr, leaf_lo, leaf_hi;
  logic        ii_req_valid;
  logic [9:0]  ii_req_x, ii_req_y;
  logic        ii_rsp_valid;
  logic [24:0] ii_rsp_data;
  logic        res_valid;
  logic [7:0]  res_value;

  always #4 clk = ~clk;

  haar_feat_eval dut_i (.*);

  int n_chk = 0, n_fail = 0;
  longint ii_mem [0:32][0:32];
  int lat = 1;

  // feature under test
  int f_n, f_ox, f_oy;
  int f_dx[4], f_dy[4], f_w[4], f_h[4];
  logic signed [7:0] f_wt[4];
  logic signed [7:0] f_thr;
  logic [7:0] f_lo, f_hi;

  // integral-image responder and request monitor
  int cnt = 0, px = 0, py = 0, nreq = 0;
  int rq_x[64], rq_y[64];
  always @(negedge clk) begin
    ii_rsp_valid <= 1'b0;
    if (cnt == 1) begin
      ii_rsp_valid <= 1'b1;
      ii_rsp_data  <= ii_mem[px][py][24:0];
    end
    if (cnt > 0) cnt <= cnt - 1;
    if (ii_req_valid) begin
      cnt <= lat;
      px  <= (ii_req_x > 32) ? 32 : int'(ii_req_x);
      py  <= (ii_req_y > 32) ? 32 : int'(ii_req_y);
      rq_x[nreq % 64] <= int'(ii_req_x);
      rq_y[nreq % 64] <= int'(ii_req_y);
      nreq <= nreq + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff_n(input int n);
    return (n < 2) ? 2 : ((n > 4) ? 4 : n);
  endfunction

  function automatic logic [7:0] model();
    longint acc = 0;
    for (int r = 0; r < eff_n(f_n); r++) begin
      int x0 = f_ox + f_dx[r], y0 = f_oy + f_dy[r];
      int x1 = x0 + f_w[r], y1 = y0 + f_h[r];
      longint s = ii_mem[x0][y0] - ii_mem[x1][y0] - ii_mem[x0][y1] + ii_mem[x1][y1];
      acc += s * longint'(f_wt[r]);
    end
    return (acc < longint'(f_thr)) ? f_lo : f_hi;
  endfunction

  task automatic drive_ports();
    feat_nrect = 3'(f_n);
    win_x = 10'(f_ox);
    win_y = 10'(f_oy);
    for (int r = 0; r < 4; r++) begin
      rect_dx[r*8 +: 8] = 8'(f_dx[r]);
      rect_dy[r*8 +: 8] = 8'(f_dy[r]);
      rect_w[r*8 +: 8]  = 8'(f_w[r]);
      rect_h[r*8 +: 8]  = 8'(f_h[r]);
      rect_wt[r*8 +: 8] = f_wt[r];
    end
    feat_thr = f_thr;
    leaf_lo  = f_lo;
    leaf_hi  = f_hi;
  endtask

  task automatic rand_feat(input int n);
    f_n = n;
    f_ox = $urandom_range(0, 8);
    f_oy = $urandom_range(0, 8);
    for (int r = 0; r < 4; r++) begin
      f_dx[r] = $urandom_range(0, 8);
      f_dy[r] = $urandom_range(0, 8);
      f_w[r]  = $urandom_range(1, 8);
      f_h[r]  = $urandom_range(1, 8);
      f_wt[r] = 8'($urandom);
    end
    f_thr = 8'($urandom);
    f_lo  = 8'($urandom_range(0, 127));
    f_hi  = f_lo + 8'd128;
  endtask

  // Run one feature. busy_noise perturbs the inputs while the block is busy.
  task automatic run_feat(input string tag, input bit busy_noise, input bit chk_order);
    logic [7:0] exp = model();
    int base = nreq;
    int got = 0;
    int en = eff_n(f_n);
    @(negedge clk);
    drive_ports();
    feat_valid = 1'b1;
    @(negedge clk);
    feat_valid = 1'b0;
    if (busy_noise) begin
      for (int k = 0; k < 3; k++) begin
        feat_valid = 1'b1;
        win_x = 10'd3; rect_dx = ~rect_dx & 32'h0303_0303;
        rect_wt = ~rect_wt; feat_thr = ~feat_thr;
        leaf_lo = 8'h5A; leaf_hi = 8'hA5; feat_nrect = 3'd4;
        @(negedge clk);
      end
      feat_valid = 1'b0;
    end
    for (int t = 0; t < 400 && !got; t++) begin
      if (res_valid) got = 1;
      else @(negedge clk);
    end
    chk(got == 1, {tag, " result arrives"}, got, 1);
    chk(res_value == exp, {tag, " leaf value"}, res_value, exp);
    chk(feat_ready == 1'b1, "R8 ready with result", feat_ready, 1);
    chk(nreq - base == 4 * en, "R3 request count", nreq - base, 4 * en);
    if (chk_order) begin
      for (int r = 0; r < en; r++)
        for (int c = 0; c < 4; c++) begin
          int ex = f_ox + f_dx[r] + ((c % 2) ? f_w[r] : 0);
          int ey = f_oy + f_dy[r] + ((c / 2) ? f_h[r] : 0);
          int i = (base + r * 4 + c) % 64;
          chk(rq_x[i] == ex && rq_y[i] == ey, "R4 corner address",
              rq_x[i] * 1000 + rq_y[i], ex * 1000 + ey);
        end
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 single pulse", res_valid, 0);
  endtask

  task automatic fill_image();
    int pix [0:31][0:31];
    for (int x = 0; x < 32; x++)
      for (int y = 0; y < 32; y++) pix[x][y] = $urandom_range(0, 255);
    for (int x = 0; x <= 32; x++)
      for (int y = 0; y <= 32; y++) begin
        if (x == 0 || y == 0) ii_mem[x][y] = 0;
        else ii_mem[x][y] = ii_mem[x-1][y] + ii_mem[x][y-1] - ii_mem[x-1][y-1] + longint'(pix[x-1][y-1]);
      end
  endtask

  task automatic t_reset();
    chk(feat_ready == 1'b1, "R1 ready after reset", feat_ready, 1);
    chk(res_valid == 1'b0, "R1 no result after reset", res_valid, 0);
    chk(ii_req_valid == 1'b0, "R1 no request after reset", ii_req_valid, 0);
  endtask

  task automatic t_two_rect();
    for (int k = 0; k < 5; k++) begin
      rand_feat(2);
      run_feat("R5 two rectangles", 1'b0, k == 0);
    end
  endtask

  task automatic t_three_four();
    for (int k = 0; k < 4; k++) begin
      rand_feat(3);
      run_feat("R6 three rectangles", 1'b0, k == 0);
      rand_feat(4);
      run_feat("R6 four rectangles", 1'b0, k == 0);
    end
  endtask

  task automatic t_count_clamp();
    int codes[4] = '{0, 1, 5, 7};
    foreach (codes[i]) begin
      rand_feat(codes[i]);
      run_feat("R3 clamped count", 1'b0, 1'b1);
    end
  endtask

  task automatic t_threshold_tie();
    // zero-size rectangles give an accumulated value of exactly 0
    rand_feat(2);
    for (int r = 0; r < 4; r++) begin f_w[r] = 0; f_h[r] = 0; end
    f_thr = 8'sd0;  run_feat("R7 equal goes high", 1'b0, 1'b0);
    chk(res_value == f_hi, "R7 tie selects leaf_hi", res_value, f_hi);
    f_thr = 8'sd1;  run_feat("R7 below goes low", 1'b0, 1'b0);
    chk(res_value == f_lo, "R7 below selects leaf_lo", res_value, f_lo);
    f_thr = -8'sd1; run_feat("R7 above goes high", 1'b0, 1'b0);
  endtask

  task automatic t_busy_ignore();
    for (int k = 0; k < 3; k++) begin
      rand_feat(2 + k);
      run_feat("R2 busy input ignored", 1'b1, 1'b1);
    end
  endtask

  task automatic t_slow_response();
    lat = 3;
    rand_feat(4); run_feat("R9 latency 3", 1'b0, 1'b1);
    lat = 5;
    rand_feat(3); run_feat("R9 latency 5", 1'b0, 1'b0);
    lat = 1;
  endtask

  task automatic t_full_scale();
    for (int x = 0; x <= 32; x++)
      for (int y = 0; y <= 32; y++) ii_mem[x][y] = 0;
    ii_mem[4][4] = 33554431;
    rand_feat(4);
    f_ox = 0; f_oy = 0;
    for (int r = 0; r < 4; r++) begin
      f_dx[r] = 0; f_dy[r] = 0; f_w[r] = 4; f_h[r] = 4; f_wt[r] = -8'sd127;
    end
    f_thr = -8'sd128;
    run_feat("R6 full scale negative", 1'b0, 1'b0);
    for (int r = 0; r < 4; r++) f_wt[r] = 8'sd127;
    f_thr = 8'sd127;
    run_feat("R6 full scale positive", 1'b0, 1'b0);
    f_wt[2] = -8'sd128; f_wt[3] = -8'sd128; f_thr = 8'sd0;
    run_feat("R6 full scale mixed", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    feat_valid = 1'b0;
    f_n = 2; f_ox = 0; f_oy = 0; f_thr = 0; f_lo = 0; f_hi = 0;
    for (int r = 0; r < 4; r++) begin
      f_dx[r] = 0; f_dy[r] = 0; f_w[r] = 0; f_h[r] = 0; f_wt[r] = 0;
    end
    drive_ports();
    fill_image();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_two_rect();
    t_three_four();
    t_count_clamp();
    t_threshold_tie();
    t_busy_ignore();
    t_slow_response();
    t_full_scale();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule